// File: doc/BRIEF.md
# Mode-selectable ripple ALU

This block is a purely combinational arithmetic and logic unit of configurable width, 4 bits by default. It is assembled from identical one-bit slices. Each slice uses the same small datapath for every operation. A conditional inverter acts on the A bit, AND gates mask the B bit and the incoming carry, and a full-adder sum and carry stage follows. Two select bits and a mode bit steer that datapath. In logic mode the carry gate is closed, so every bit works on its own. In arithmetic mode the carry passes from each slice to the next one up.

Because the operand gating is shared, one adder structure gives two sets of results. Logic mode gives pass, invert, XOR and XNOR. Arithmetic mode gives pass, invert, add and complement-add, and each of these is optionally incremented by the carry input. With the carry input set, the complement-add becomes B minus A, and invert becomes the two's complement of A. The block has no clock. A surrounding pipeline registers its inputs and outputs.

Top module: `alu_gx_top`

## Requirements
- R1: With mode_arith=0 and sel[1]=0, f_out equals a_in when sel[0]=0 and the bitwise complement of a_in when sel[0]=1 (sel[1] is S1, sel[0] is S0).
- R2: With mode_arith=0 and sel[1]=1, f_out equals a_in XOR b_in when sel[0]=0 and a_in XNOR b_in when sel[0]=1.
- R3: With mode_arith=0, carry_in has no effect on f_out.
- R4: With mode_arith=0, carry_out is 0 for every operand and select value.
- R5: With mode_arith=1 and carry_in=0, {carry_out,f_out} is the (WIDTH+1)-bit sum for each sel code: 00 gives A, 01 gives NOT A, 10 gives A+B and 11 gives (NOT A)+B.
- R6: With mode_arith=1 and carry_in=1, {carry_out,f_out} is the (WIDTH+1)-bit sum for each sel code: 00 gives A+1, 01 gives (NOT A)+1, 10 gives A+B+1 and 11 gives (NOT A)+B+1, which is B minus A.
- R7: When sel[1]=0, b_in has no effect on f_out or carry_out, in either mode.
- R8: In arithmetic mode a carry travels the full width: an all-ones a_in with sel=00 and carry_in=1 gives f_out=0 and carry_out=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B, masked when sel[1]=0 |
| sel | input | 2 | Operation select; bit 1 enables B, bit 0 inverts A |
| mode_arith | input | 1 | 1 selects arithmetic (rippled carry), 0 selects bitwise logic |
| carry_in | input | 1 | Carry into the least significant slice, used only in arithmetic mode |
| f_out | output | WIDTH | Result |
| carry_out | output | 1 | Carry out of the top slice in arithmetic mode, 0 in logic mode |

## Verification
The checks inside the top module are evaluated on the settled combinational outputs. They assume that every input holds a known two-state value and that all inputs move together, so no intermediate mix of old and new operands appears. The stimulus meets this by driving every input in a single step just after a rising clock edge and holding it for the whole cycle. It reads the results at the following falling edge, when the ripple chain has settled.

// File: rtl/alu_gx_pkg.sv
package alu_gx_pkg;

  typedef enum logic [1:0] {
    SEL_PASS_A = 2'b00,
    SEL_INV_A  = 2'b01,
    SEL_WITH_B = 2'b10,
    SEL_INVA_B = 2'b11
  } alu_sel_e;

  typedef struct packed {
    logic inv_a;
    logic use_b;
    logic chain_en;
  } slice_ctl_t;

endpackage

// File: rtl/alu_gx_ctl.sv
module alu_gx_ctl
  import alu_gx_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       mode_arith,
  output slice_ctl_t ctl
);

  alu_sel_e sel_code;

  always_comb begin
    sel_code     = alu_sel_e'(sel);
    ctl.inv_a    = (sel_code == SEL_INV_A) || (sel_code == SEL_INVA_B);
    ctl.use_b    = (sel_code == SEL_WITH_B) || (sel_code == SEL_INVA_B);
    ctl.chain_en = mode_arith;
  end

endmodule

// File: rtl/alu_gx_slice.sv
module alu_gx_slice
  import alu_gx_pkg::*;
(
  input  logic       ai,
  input  logic       bi,
  input  logic       ci,
  input  slice_ctl_t ctl,
  output logic       fi,
  output logic       co
);

  logic a_cond;
  logic b_gate;
  logic c_gate;
  logic ac_x;

  always_comb begin
    a_cond = ai ^ ctl.inv_a;
    b_gate = bi & ctl.use_b;
    c_gate = ci & ctl.chain_en;
    ac_x   = a_cond ^ c_gate;
    fi     = ac_x ^ b_gate;
    co     = (a_cond & c_gate) | (b_gate & ac_x);
  end

endmodule

// File: rtl/alu_gx_chain.sv
module alu_gx_chain
  import alu_gx_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_vec,
  input  logic [WIDTH-1:0] b_vec,
  input  logic             c_first,
  input  slice_ctl_t       ctl,
  output logic [WIDTH-1:0] f_vec,
  output logic             c_last
);

  localparam int NODES = WIDTH + 1;

  logic [NODES-1:0] carry_node;

  assign carry_node[0] = c_first;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
    alu_gx_slice u_slice (
      .ai  (a_vec[gi]),
      .bi  (b_vec[gi]),
      .ci  (carry_node[gi]),
      .ctl (ctl),
      .fi  (f_vec[gi]),
      .co  (carry_node[gi+1])
    );
  end

  assign c_last = carry_node[NODES-1];

endmodule

// File: rtl/alu_gx_top.sv
module alu_gx_top
  import alu_gx_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [1:0]       sel,
  input  logic             mode_arith,
  input  logic             carry_in,
  output logic [WIDTH-1:0] f_out,
  output logic             carry_out
);

  localparam int EXT = WIDTH + 1;

  slice_ctl_t ctl;
  logic       chain_co;

  alu_gx_ctl u_ctl (
    .sel        (sel),
    .mode_arith (mode_arith),
    .ctl        (ctl)
  );

  alu_gx_chain #(.WIDTH(WIDTH)) u_chain (
    .a_vec   (a_in),
    .b_vec   (b_in),
    .c_first (carry_in),
    .ctl     (ctl),
    .f_vec   (f_out),
    .c_last  (chain_co)
  );

  assign carry_out = chain_co & ctl.chain_en;

  logic [EXT-1:0] arith_ref;
  logic [WIDTH-1:0] a_opnd;

  always_comb begin
    a_opnd    = sel[0] ? ~a_in : a_in;
    arith_ref = EXT'(a_opnd) + (sel[1] ? EXT'(b_in) : '0) + EXT'(carry_in);
    if (!mode_arith && !sel[1])
      AST_LOGIC_UNARY: assert (f_out == (a_in ^ {WIDTH{sel[0]}})) else $error("unary logic"); // R1
    if (!mode_arith && sel[1])
      AST_LOGIC_BINARY: assert (f_out == (a_in ^ b_in ^ {WIDTH{sel[0]}})) else $error("binary logic"); // R2
    if (!mode_arith)
      AST_LOGIC_NO_CARRY: assert (carry_out == 1'b0) else $error("carry in logic mode"); // R4
    if (mode_arith && !carry_in)
      AST_ARITH_NO_CIN: assert ({carry_out, f_out} == arith_ref) else $error("arith no cin"); // R5
    if (mode_arith && carry_in)
      AST_ARITH_CIN: assert ({carry_out, f_out} == arith_ref) else $error("arith cin"); // R6
  end

endmodule

// File: tb/alu_gx_top_test.sv
module alu_gx_top_test;

  localparam int W = 4;
  localparam int LIMIT = 200000;

  logic clk;
  logic rst_n;
  logic [W-1:0] a_in, b_in;
  logic [1:0] sel;
  logic mode_arith, carry_in;
  logic [W-1:0] f_out;
  logic carry_out;

  int total = 0;
  int bad = 0;
  bit stim_done = 0;
  bit reported = 0;

  logic [W:0] exp_q[$];
  string tag_q[$];

  alu_gx_top #(.WIDTH(W)) uut (
    .a_in(a_in), .b_in(b_in), .sel(sel), .mode_arith(mode_arith),
    .carry_in(carry_in), .f_out(f_out), .carry_out(carry_out)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic [1:0] s, input logic m, input logic c);
    logic [W:0] r;
    if (!m) begin
      case (s)
        2'b00: r = {1'b0, a};
        2'b01: r = {1'b0, ~a};
        2'b10: r = {1'b0, a ^ b};
        default: r = {1'b0, ~(a ^ b)};
      endcase
    end else begin
      case (s)
        2'b00: r = {1'b0, a} + (W+1)'(c);
        2'b01: r = {1'b0, ~a} + (W+1)'(c);
        2'b10: r = {1'b0, a} + {1'b0, b} + (W+1)'(c);
        default: r = {1'b0, ~a} + {1'b0, b} + (W+1)'(c);
      endcase
    end
    return r;
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] s,
                       input logic m, input logic c, input string tag);
    @(posedge clk);
    #1;
    a_in = a; b_in = b; sel = s; mode_arith = m; carry_in = c;
    exp_q.push_back(model(a, b, s, m, c));
    tag_q.push_back(tag);
  endtask

  task automatic drive_fixed(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] s,
                             input logic m, input logic c, input logic [W:0] expv, input string tag);
    @(posedge clk);
    #1;
    a_in = a; b_in = b; sel = s; mode_arith = m; carry_in = c;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [W:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if ({carry_out, f_out} !== e) begin
        bad++;
        $display("FAIL %s: got cn=%b f=%h expected cn=%b f=%h", t, carry_out, f_out, e[W], e[W-1:0]);
      end
    end
  end

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    a_in = '0; b_in = '0; sel = 2'b00; mode_arith = 0; carry_in = 0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    rst_n = 1;
    drive_fixed('0, '0, 2'b00, 0, 0, '0, "R1 idle zero");
    drive_fixed({W{1'b1}}, '0, 2'b00, 1, 1, {1'b1, {W{1'b0}}}, "R8 full ripple");
    drive_fixed('0, '0, 2'b01, 1, 1, {1'b1, {W{1'b0}}}, "R6 negate zero");
    drive_fixed(4'h5, 4'h5, 2'b11, 1, 1, {1'b1, 4'h0}, "R6 B minus A equal");
    drive_fixed(4'h3, 4'h9, 2'b11, 1, 1, {1'b1, 4'h6}, "R6 B minus A");
    drive_fixed(4'hF, 4'hF, 2'b10, 0, 1, {1'b0, 4'h0}, "R4 logic xor no carry");
    drive_fixed(4'hA, 4'h6, 2'b10, 1, 0, {1'b1, 4'h0}, "R5 add overflow");
    for (int k = 0; k < 16; k++) begin
      for (int n = 0; n < 40; n++) begin
        logic [W-1:0] a, b, b2;
        logic [1:0] s;
        logic m, c;
        a = W'($urandom); b = W'($urandom); b2 = W'($urandom);
        s = k[1:0]; c = k[2]; m = k[3];
        if (!m) begin
          drive(a, b, s, m, c, s[1] ? "R2 R4 logic binary" : "R1 R4 logic unary");
          drive(a, b, s, m, ~c, "R3 carry ignored in logic");
        end else begin
          drive(a, b, s, m, c, c ? "R6 arith cin" : "R5 arith no cin");
        end
        if (!s[1]) drive(a, b2, s, m, c, "R7 B ignored");
      end
    end
    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    stim_done = 1;
    finish_run();
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!stim_done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    finish_run();
  end

endmodule